// File: doc/BRIEF.md
# DMA-to-Byte Parity FIFO

This block sits between a 16-bit DMA port and an 8-bit peripheral byte port. It holds sixteen entries, and each entry is one byte plus its own parity bit. The direction input picks which way the DMA acknowledge moves data.

When data flows toward the byte port, each acknowledged DMA word is split into two entries, low byte first. When data flows toward the DMA side, pairs of entries are packed back into a word, and a DMA request is raised once a burst of eight bytes can be served. A flush mode also lets a last odd byte leave through the low lane.

Parity is either generated and checked, or carried through untouched. The byte port can pop entries in either direction, so the host can drain bytes left behind after an aborted transfer. Flag outputs report occupancy, overflow, underflow and parity errors, and a synchronous clear empties the buffer in one cycle.

Top module: `dma_byte_fifo`

## Requirements
- R1: After reset the occupancy is 0, `empty` is 1, `full` is 0 and the three error flags are 0. At all times `empty` equals (count == 0) and `full` equals (count == 16).
- R2: With `dma_dir`=0 and `dma_ack`=1, the word on `dma_wdata` becomes two entries, bits 7:0 first and bits 15:8 second. If fewer than two entries are free, nothing is stored and the sticky `ovf` flag is set.
- R3: `byte_rdata`/`byte_rpar` always present the oldest entry. A `byte_pop` removes exactly one entry.
- R4: `byte_push` stores `{byte_wpar, byte_wdata}` as one entry. When the buffer is full the push is refused and `ovf` is set.
- R5: While two or more entries are held, `dma_rdata` is {second oldest, oldest} and `dma_rpar` carries their parity bits in the same lanes. With `dma_dir`=1 and `dma_ack`=1, two entries are removed.
- R6: With `dma_dir`=1, `dreq` is 1 when the count is at least 8, or when `flush_mode` is 1 and the count is at least 1. With `dma_dir`=0, `dreq` is 1 when at least 8 entries are free.
- R7: When exactly one entry is held, `dma_rdata` is {8'h00, that byte} and `dma_rpar` is {1, its parity}. A DMA read then removes the entry only if `flush_mode` is 1.
- R8: With `par_gen`=1, each byte written from the DMA port gets odd parity: the bit is 1 when the byte has an even number of ones. With `par_gen`=0, the received `dma_wpar` bit for that lane is stored.
- R9: With `par_gen`=1, every entry popped on either port is checked for odd parity. A mismatch sets `perr`, which stays set until `perr_clr` or `clr`. If a new error and `perr_clr` arrive in the same cycle, the flag is set.
- R10: With `par_gen`=0, no pop ever sets `perr`.
- R11: A pop that asks for more entries than are held is refused, leaves the count unchanged and sets the sticky `udf` flag.
- R12: `clr` empties the buffer and clears `ovf`, `udf` and `perr` in one cycle. Any push or pop in that cycle is dropped.
- R13: When `dma_ack` is active on a side, it wins over the byte strobe on that side. With `dma_dir`=0 a `byte_push` is ignored; with `dma_dir`=1 a `byte_pop` is ignored.
- R14: A push and a pop in the same cycle are both judged against the occupancy before that cycle, and the count moves by their net difference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_dir | input | 1 | 0: DMA writes into buffer; 1: DMA reads from buffer |
| par_gen | input | 1 | 1: generate/check parity; 0: pass parity through |
| flush_mode | input | 1 | Allow a single last byte to leave on the DMA side |
| clr | input | 1 | Synchronous clear of contents and error flags |
| perr_clr | input | 1 | Clears the parity error flag |
| dma_ack | input | 1 | DMA acknowledge, one word per cycle |
| dma_wdata | input | 16 | DMA write word |
| dma_wpar | input | 2 | DMA write parity, one bit per byte lane |
| dma_rdata | output | 16 | DMA read word |
| dma_rpar | output | 2 | DMA read parity, one bit per byte lane |
| dreq | output | 1 | DMA request |
| byte_push | input | 1 | Byte port write strobe |
| byte_wdata | input | 8 | Byte port write data |
| byte_wpar | input | 1 | Byte port write parity |
| byte_pop | input | 1 | Byte port read / drain strobe |
| byte_rdata | output | 8 | Oldest byte |
| byte_rpar | output | 1 | Parity of oldest byte |
| count | output | 5 | Number of held entries |
| empty | output | 1 | No entries held |
| full | output | 1 | Sixteen entries held |
| ovf | output | 1 | Sticky refused-push flag |
| udf | output | 1 | Sticky refused-pop flag |
| perr | output | 1 | Sticky parity error flag |

## Verification
The bench targets these corner cases:
- A word write when exactly one slot is free. A design that checked only for a single free slot would wrap over the oldest byte.
- A single remaining byte on the DMA side, with and without flush mode. A design that got this wrong would either hang the request or leak a stale high byte instead of zero.
- A parity error that coincides with its own clear, plus bad parity in pass-through mode. A wrong priority here loses errors or reports false ones.
- Simultaneous acknowledge and byte strobes, and pushes and pops at full and empty. A wrong occupancy rule here double-counts or shifts the byte order.

// File: rtl/dbf_pkg.sv
package dbf_pkg;

  typedef struct packed {
    logic       par;
    logic [7:0] data;
  } dbf_entry_t;

  function automatic logic odd_par(input logic [7:0] b);
    return ~^b;
  endfunction

endpackage

// File: rtl/dbf_mem.sv
module dbf_mem
  import dbf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic       clk,
  input  logic       we0,
  input  logic       we1,
  input  logic [AW-1:0] wa0,
  input  logic [AW-1:0] wa1,
  input  dbf_entry_t wd0,
  input  dbf_entry_t wd1,
  input  logic [AW-1:0] ra0,
  input  logic [AW-1:0] ra1,
  output dbf_entry_t rd0,
  output dbf_entry_t rd1
);

  dbf_entry_t mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we0) mem_q[wa0] <= wd0;
    if (we1) mem_q[wa1] <= wd1;
  end

  assign rd0 = mem_q[ra0];
  assign rd1 = mem_q[ra1];

endmodule

// File: rtl/dbf_ctrl.sv
module dbf_ctrl #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int CW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [1:0]    push_n,
  input  logic [1:0]    pop_n,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] cnt,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          ovf,
  output logic          udf,
  output logic          empty,
  output logic          full
);

  logic [AW-1:0] wr_q, wr_nx, rd_q, rd_nx;
  logic [CW-1:0] cnt_q, cnt_nx, free, n_in, n_out;
  logic          ovf_q, ovf_nx, udf_q, udf_nx;

  always_comb begin
    free    = CW'(DEPTH) - cnt_q;
    push_ok = !clr && (push_n != 2'd0) && (CW'(push_n) <= free);
    pop_ok  = !clr && (pop_n != 2'd0) && (CW'(pop_n) <= cnt_q);
    n_in    = push_ok ? CW'(push_n) : '0;
    n_out   = pop_ok ? CW'(pop_n) : '0;
    if (clr) begin
      wr_nx  = '0;
      rd_nx  = '0;
      cnt_nx = '0;
      ovf_nx = 1'b0;
      udf_nx = 1'b0;
    end else begin
      wr_nx  = wr_q + AW'(n_in);
      rd_nx  = rd_q + AW'(n_out);
      cnt_nx = cnt_q + n_in - n_out;
      ovf_nx = ovf_q | ((push_n != 2'd0) && !push_ok);
      udf_nx = udf_q | ((pop_n != 2'd0) && !pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      wr_q  <= wr_nx;
      rd_q  <= rd_nx;
      cnt_q <= cnt_nx;
      ovf_q <= ovf_nx;
      udf_q <= udf_nx;
    end
  end

  assign wr_ptr = wr_q;
  assign rd_ptr = rd_q;
  assign cnt    = cnt_q;
  assign ovf    = ovf_q;
  assign udf    = udf_q;
  assign empty  = (cnt_q == '0);
  assign full   = (cnt_q == CW'(DEPTH));

  // R14
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R2
  word_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && push_n == 2'd2 && !pop_ok) |=> (cnt_q == $past(cnt_q) + CW'(2)));

  // R4
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr) |=> ovf_q);

  // R11
  udf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_n != 2'd0 && !pop_ok && push_n == 2'd0 && !clr) |=> ($stable(cnt_q) && udf_q));

  // R12
  clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0 && !ovf_q && !udf_q));

endmodule

// File: rtl/dbf_lanes.sv
module dbf_lanes
  import dbf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int BURST = 8,
  parameter int CW    = 5
) (
  input  logic          dma_dir,
  input  logic          dma_ack,
  input  logic          par_gen,
  input  logic          flush_mode,
  input  logic [15:0]   dma_wdata,
  input  logic [1:0]    dma_wpar,
  input  logic          byte_push,
  input  logic [7:0]    byte_wdata,
  input  logic          byte_wpar,
  input  logic          byte_pop,
  input  logic [CW-1:0] cnt,
  input  dbf_entry_t    rd0,
  input  dbf_entry_t    rd1,
  output logic [1:0]    push_n,
  output logic [1:0]    pop_n,
  output dbf_entry_t    wd0,
  output dbf_entry_t    wd1,
  output logic [15:0]   dma_rdata,
  output logic [1:0]    dma_rpar,
  output logic [7:0]    byte_rdata,
  output logic          byte_rpar,
  output logic          dreq
);

  dbf_entry_t lane_wr [2];
  logic       dma_word_in, dma_word_out, single;

  for (genvar l = 0; l < 2; l++) begin : g_lane
    assign lane_wr[l].data = dma_wdata[8*l +: 8];
    assign lane_wr[l].par  = par_gen ? odd_par(dma_wdata[8*l +: 8]) : dma_wpar[l];
  end

  always_comb begin
    dma_word_in  = !dma_dir && dma_ack;
    dma_word_out = dma_dir && dma_ack;
    single       = (cnt < CW'(2));

    if (dma_word_in)    push_n = 2'd2;
    else if (byte_push) push_n = 2'd1;
    else                push_n = 2'd0;

    if (dma_word_out)   pop_n = (single && flush_mode && cnt != '0) ? 2'd1 : 2'd2;
    else if (byte_pop)  pop_n = 2'd1;
    else                pop_n = 2'd0;

    wd0 = dma_word_in ? lane_wr[0] : '{par: byte_wpar, data: byte_wdata};
    wd1 = lane_wr[1];

    if (single) begin
      dma_rdata = {8'h00, rd0.data};
      dma_rpar  = {1'b1, rd0.par};
    end else begin
      dma_rdata = {rd1.data, rd0.data};
      dma_rpar  = {rd1.par, rd0.par};
    end

    byte_rdata = rd0.data;
    byte_rpar  = rd0.par;

    if (dma_dir) dreq = (cnt >= CW'(BURST)) || (flush_mode && cnt != '0);
    else         dreq = (CW'(DEPTH) - cnt) >= CW'(BURST);
  end

endmodule

// File: rtl/dbf_pchk.sv
module dbf_pchk
  import dbf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       perr_clr,
  input  logic       chk_en,
  input  logic       pop_ok,
  input  logic [1:0] pop_n,
  input  dbf_entry_t rd0,
  input  dbf_entry_t rd1,
  output logic       perr
);

  logic perr_q, perr_nx, bad0, bad1, hit;

  always_comb begin
    bad0 = rd0.par != odd_par(rd0.data);
    bad1 = rd1.par != odd_par(rd1.data);
    hit  = pop_ok && chk_en && (bad0 || (pop_n == 2'd2 && bad1));
    if (clr)           perr_nx = 1'b0;
    else if (hit)      perr_nx = 1'b1;
    else if (perr_clr) perr_nx = 1'b0;
    else               perr_nx = perr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) perr_q <= 1'b0;
    else        perr_q <= perr_nx;
  end

  assign perr = perr_q;

  // R9
  perr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_q && !perr_clr && !clr) |=> perr_q);

  // R10
  passthru_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chk_en && !perr_q) |=> !perr_q);

endmodule

// File: rtl/dma_byte_fifo.sv
module dma_byte_fifo
  import dbf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int BURST = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dma_dir,
  input  logic        par_gen,
  input  logic        flush_mode,
  input  logic        clr,
  input  logic        perr_clr,
  input  logic        dma_ack,
  input  logic [15:0] dma_wdata,
  input  logic [1:0]  dma_wpar,
  output logic [15:0] dma_rdata,
  output logic [1:0]  dma_rpar,
  output logic        dreq,
  input  logic        byte_push,
  input  logic [7:0]  byte_wdata,
  input  logic        byte_wpar,
  input  logic        byte_pop,
  output logic [7:0]  byte_rdata,
  output logic        byte_rpar,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic        empty,
  output logic        full,
  output logic        ovf,
  output logic        udf,
  output logic        perr
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic [1:0]    push_n, pop_n;
  logic          push_ok, pop_ok;
  dbf_entry_t    wd0, wd1, rd0, rd1;

  dbf_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clr(clr), .push_n(push_n), .pop_n(pop_n),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .cnt(cnt), .push_ok(push_ok), .pop_ok(pop_ok),
    .ovf(ovf), .udf(udf), .empty(empty), .full(full)
  );

  dbf_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk(clk),
    .we0(push_ok), .we1(push_ok && push_n == 2'd2),
    .wa0(wr_ptr), .wa1(wr_ptr + AW'(1)),
    .wd0(wd0), .wd1(wd1),
    .ra0(rd_ptr), .ra1(rd_ptr + AW'(1)),
    .rd0(rd0), .rd1(rd1)
  );

  dbf_lanes #(.DEPTH(DEPTH), .BURST(BURST), .CW(CW)) u_lanes (
    .dma_dir(dma_dir), .dma_ack(dma_ack), .par_gen(par_gen), .flush_mode(flush_mode),
    .dma_wdata(dma_wdata), .dma_wpar(dma_wpar),
    .byte_push(byte_push), .byte_wdata(byte_wdata), .byte_wpar(byte_wpar),
    .byte_pop(byte_pop), .cnt(cnt), .rd0(rd0), .rd1(rd1),
    .push_n(push_n), .pop_n(pop_n), .wd0(wd0), .wd1(wd1),
    .dma_rdata(dma_rdata), .dma_rpar(dma_rpar),
    .byte_rdata(byte_rdata), .byte_rpar(byte_rpar), .dreq(dreq)
  );

  dbf_pchk u_pchk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .perr_clr(perr_clr), .chk_en(par_gen),
    .pop_ok(pop_ok), .pop_n(pop_n), .rd0(rd0), .rd1(rd1), .perr(perr)
  );

  assign count = cnt;

  // R6
  dreq_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_dir && dreq) |-> !empty);

  // R1
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));

endmodule

// File: tb/sim_dma_byte_fifo.sv
`timescale 1ns/1ps
module sim_dma_byte_fifo;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        dma_dir, par_gen, flush_mode, clr, perr_clr, dma_ack;
  logic [15:0] dma_wdata;
  logic [1:0]  dma_wpar;
  logic [15:0] dma_rdata;
  logic [1:0]  dma_rpar;
  logic        dreq;
  logic        byte_push, byte_wpar, byte_pop;
  logic [7:0]  byte_wdata, byte_rdata;
  logic        byte_rpar;
  logic [4:0]  count;
  logic        empty, full, ovf, udf, perr;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  logic [8:0] q[$];
  bit m_ovf, m_udf, m_perr;

  always #2.5 clk = ~clk;

  dma_byte_fifo u0 (
    .clk(clk), .rst_n(rst_n), .dma_dir(dma_dir), .par_gen(par_gen),
    .flush_mode(flush_mode), .clr(clr), .perr_clr(perr_clr), .dma_ack(dma_ack),
    .dma_wdata(dma_wdata), .dma_wpar(dma_wpar), .dma_rdata(dma_rdata),
    .dma_rpar(dma_rpar), .dreq(dreq), .byte_push(byte_push),
    .byte_wdata(byte_wdata), .byte_wpar(byte_wpar), .byte_pop(byte_pop),
    .byte_rdata(byte_rdata), .byte_rpar(byte_rpar), .count(count),
    .empty(empty), .full(full), .ovf(ovf), .udf(udf), .perr(perr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    dma_ack = 0; byte_push = 0; byte_pop = 0; clr = 0; perr_clr = 0;
  endtask

  // Behavioural reference: one call per clock, using the inputs held for that edge
  task automatic step();
    int sz;
    int pops;
    int pushes;
    bit bad;
    sz = q.size(); pops = 0; pushes = 0; bad = 0;
    if (clr) begin
      q.delete(); m_ovf = 0; m_udf = 0; m_perr = 0;
      return;
    end
    if (dma_dir && dma_ack) begin
      if (sz >= 2) pops = 2;
      else if (sz == 1 && flush_mode) pops = 1;
      else m_udf = 1;
    end else if (byte_pop) begin
      if (sz >= 1) pops = 1; else m_udf = 1;
    end
    if (!dma_dir && dma_ack) begin
      if (16 - sz >= 2) pushes = 2; else m_ovf = 1;
    end else if (byte_push) begin
      if (16 - sz >= 1) pushes = 1; else m_ovf = 1;
    end
    for (int i = 0; i < pops; i++)
      if (par_gen && (q[i][8] != ~^q[i][7:0])) bad = 1;
    if (bad) m_perr = 1;
    else if (perr_clr) m_perr = 0;
    for (int i = 0; i < pops; i++) void'(q.pop_front());
    if (pushes == 2) begin
      q.push_back({par_gen ? ~^dma_wdata[7:0]  : dma_wpar[0], dma_wdata[7:0]});
      q.push_back({par_gen ? ~^dma_wdata[15:8] : dma_wpar[1], dma_wdata[15:8]});
    end else if (pushes == 1) begin
      q.push_back({byte_wpar, byte_wdata});
    end
  endtask

  task automatic compare();
    int sz;
    bit exp_dreq;
    sz = q.size();
    exp_dreq = dma_dir ? (sz >= 8 || (flush_mode && sz >= 1)) : (16 - sz >= 8);
    chk("R14 count", count, sz);
    chk("R1 empty", empty, sz == 0);
    chk("R1 full", full, sz == 16);
    chk("R4 ovf", ovf, m_ovf);
    chk("R11 udf", udf, m_udf);
    chk("R9 perr", perr, m_perr);
    chk("R6 dreq", dreq, exp_dreq);
    if (sz >= 1) begin
      chk("R3 byte_rdata", byte_rdata, q[0][7:0]);
      chk("R3 byte_rpar", byte_rpar, q[0][8]);
    end
    if (sz >= 2) begin
      chk("R5 dma_rdata", dma_rdata, {q[1][7:0], q[0][7:0]});
      chk("R5 dma_rpar", dma_rpar, {q[1][8], q[0][8]});
    end else if (sz == 1) begin
      chk("R7 dma_rdata", dma_rdata, {8'h00, q[0][7:0]});
      chk("R7 dma_rpar", dma_rpar, {1'b1, q[0][8]});
    end
  endtask

  task automatic cycle();
    step();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  initial begin
    #(150000 * 5);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    dma_dir = 0; par_gen = 1; flush_mode = 0;
    dma_wdata = '0; dma_wpar = '0; byte_wdata = '0; byte_wpar = 0;
    idle();
    m_ovf = 0; m_udf = 0; m_perr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset count", count, 0);
    chk("R1 reset empty", empty, 1);
    chk("R1 reset full", full, 0);
    chk("R1 reset flags", {ovf, udf, perr}, 0);
    compare();

    // R2 / R8: word split low first, parity generated (received parity ignored)
    dma_ack = 1; dma_wdata = 16'h0301; dma_wpar = 2'b11;
    cycle(); idle();
    chk("R2 word count", count, 2);
    chk("R8 low byte", byte_rdata, 8'h01);
    chk("R8 low parity", byte_rpar, 0);
    byte_pop = 1; cycle();
    chk("R3 second byte", byte_rdata, 8'h03);
    chk("R8 high parity", byte_rpar, 1);
    cycle(); idle();
    chk("R3 drained", count, 0);

    // R2: fill with words then overflow
    for (int i = 0; i < 8; i++) begin
      dma_ack = 1; dma_wdata = 16'(i * 257 + 16'h1020); cycle();
    end
    chk("R1 full after fill", full, 1);
    cycle();
    idle();
    chk("R2 refused word", count, 16);
    chk("R2 ovf set", ovf, 1);

    // R12: clear wins over a pop in the same cycle
    clr = 1; byte_pop = 1; cycle(); idle();
    chk("R12 cleared count", count, 0);
    chk("R12 cleared ovf", ovf, 0);

    // R13: DMA word wins over byte push
    dma_ack = 1; dma_wdata = 16'h1234; byte_push = 1; byte_wdata = 8'h55;
    cycle(); idle();
    chk("R13 only word stored", count, 2);
    chk("R13 low byte first", byte_rdata, 8'h34);
    clr = 1; cycle(); idle();

    // R6 / R5: byte pushes toward the DMA side, pass-through parity
    dma_dir = 1; par_gen = 0;
    for (int i = 0; i < 9; i++) begin
      byte_push = 1; byte_wdata = 8'(8'h10 + i); byte_wpar = i[0];
      cycle();
      if (i == 6) chk("R6 dreq below burst", dreq, 0);
      if (i == 7) chk("R6 dreq at burst", dreq, 1);
    end
    idle(); cycle();
    chk("R5 packed word", dma_rdata, 16'h1110);
    chk("R5 packed parity", dma_rpar, 2'b10);
    dma_ack = 1; cycle(); idle();
    chk("R5 two popped", count, 7);
    dma_ack = 1; byte_pop = 1; cycle(); idle();
    chk("R13 byte pop ignored", count, 5);
    dma_ack = 1; cycle(); cycle(); idle();
    chk("R5 one left", count, 1);
    chk("R6 no dreq single", dreq, 0);
    dma_ack = 1; cycle(); idle();
    chk("R11 refused read count", count, 1);
    chk("R11 udf set", udf, 1);
    flush_mode = 1; cycle();
    chk("R6 flush dreq", dreq, 1);
    chk("R7 low lane", dma_rdata, 16'h0018);
    chk("R7 lane parity", dma_rpar, 2'b10);
    dma_ack = 1; cycle(); idle();
    chk("R7 single popped", count, 0);
    flush_mode = 0;

    // R10: bad parity in pass-through
    byte_push = 1; byte_wdata = 8'h07; byte_wpar = 1; cycle(); idle();
    byte_pop = 1; cycle(); idle();
    chk("R10 no perr", perr, 0);
    // R9: bad parity in check mode, sticky, then cleared
    par_gen = 1;
    byte_push = 1; cycle(); idle();
    byte_pop = 1; cycle(); idle();
    chk("R9 perr set", perr, 1);
    cycle();
    chk("R9 perr sticky", perr, 1);
    perr_clr = 1; cycle(); idle();
    chk("R9 perr cleared", perr, 0);

    // R14 and all: random traffic compared every clock
    for (int n = 0; n < 6000; n++) begin
      if ($urandom_range(63) == 0) dma_dir = ~dma_dir;
      if ($urandom_range(127) == 0) par_gen = ~par_gen;
      if ($urandom_range(31) == 0) flush_mode = ~flush_mode;
      dma_ack    = ($urandom_range(3) == 0);
      byte_push  = ($urandom_range(1) == 0);
      byte_pop   = ($urandom_range(1) == 0);
      dma_wdata  = 16'($urandom);
      dma_wpar   = 2'($urandom);
      byte_wdata = 8'($urandom);
      byte_wpar  = ($urandom_range(5) == 0) ? ~(~^byte_wdata) : ~^byte_wdata;
      perr_clr   = ($urandom_range(40) == 0);
      clr        = ($urandom_range(250) == 0);
      cycle();
    end
    idle();
    cycle();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule